// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a 32-bit multiplexed address/data bus and its four active-low byte-enable lines with a single even-parity bit. When the local agent drives the bus, it computes the parity bit for every cycle and presents it one clock later. When it receives, it recomputes parity over the received lines and compares it with the parity bit the remote agent sends one clock later.

Mismatches are reported on two active-low strobes. A bad address phase raises the system-error strobe and a bad data phase raises the parity-error strobe. Each strobe has its own enable. A sticky flag records every detected error whatever the enables are, and holds it until a clear pulse arrives. The block finds address phases and completed data phases on its own from the framing and ready qualifiers. Arbitration, command decoding and configuration storage belong to other blocks.

Top module: `pci_parity_unit`

## Requirements
- R1: After each rising edge, `par_o` equals the XOR of all bits of `ad_i` and `cbe_n_i` sampled at that edge, so that the ones across the 36 lines plus the parity bit are even.
- R2: After each rising edge, `par_oe_o` equals `drive_i` sampled at that edge.
- R3: An address phase is an edge where `frame_n_i` is 0 and, at the previous edge, `frame_n_i` and `irdy_n_i` were both 1 (after reset, the previous edge counts as idle). A data phase is any other edge where `irdy_n_i` and `trdy_n_i` are both 0.
- R4: If the parity of an address phase at edge k differs from `par_i` sampled at edge k+1, and `serr_en_i` is 1 at edge k+2, then `serr_n_o` is 0 for exactly the clock that follows edge k+2.
- R5: While `serr_en_i` is 0 at edge k+2, `serr_n_o` stays 1 for an address parity error from edge k.
- R6: Each data phase at edge k whose parity differs from `par_i` at edge k+1 drives `perr_n_o` to 0 for the one clock after edge k+2, provided `perr_en_i` is 1 at edge k+2. Back-to-back bad phases give back-to-back low clocks.
- R7: A phase during which `drive_i` is 1 is never checked: it can cause no strobe and does not set the sticky flag.
- R8: `sts_perr_o` becomes 1 after edge k+2 for any detected address or data parity error, whatever the enables are. It returns to 0 only after an edge where `sts_clr_i` is 1 and no new error is being recorded; setting wins over clearing.
- R9: While `rst_n` is 0: `par_o` and `par_oe_o` are 0, `perr_n_o` and `serr_n_o` are 1, and `sts_perr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command / byte-enable lines, active low, bit 0 for AD[7:0] |
| frame_n_i | input | 1 | Transaction framing, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| drive_i | input | 1 | 1 when the local agent drives AD and C/BE this clock |
| par_i | input | 1 | Parity bit received from the bus |
| perr_en_i | input | 1 | Enables the parity-error strobe |
| serr_en_i | input | 1 | Enables the system-error strobe |
| sts_clr_i | input | 1 | Write-one pulse that clears the sticky flag |
| par_o | output | 1 | Generated parity, one clock after the lines it covers |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | Data parity error strobe, active low |
| serr_n_o | output | 1 | Address parity error strobe, active low |
| sts_perr_o | output | 1 | Sticky parity-error flag |

## Verification
The generated parity bit and its enable are due one clock after the edge that samples the lines they cover. Both error strobes and the sticky flag are due after the second edge that follows the phase, and the received parity bit that decides them is taken at the edge in between. The bench model keeps a three-deep history of phase records and received parity bits, so it lines up each phase with the parity bit one edge later and the result two edges later. Inputs change on falling edges and outputs are compared on the following falling edge, so every clock's results are checked exactly once and in the cycle they are due.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/pcipar_phase.sv
module pcipar_phase
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_n_i,
  input  logic   irdy_n_i,
  input  logic   trdy_n_i,
  output phase_e phase_o
);
  logic idle_q, idle_d;

  // bus is idle when neither framing nor initiator-ready is asserted
  always_comb begin
    idle_d = frame_n_i & irdy_n_i;
    if (idle_q && !frame_n_i)
      phase_o = PH_ADDR;
    else if (!irdy_n_i && !trdy_n_i)
      phase_o = PH_DATA;
    else
      phase_o = PH_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b1;
    else        idle_q <= idle_d;
  end
endmodule

// File: rtl/pcipar_gen.sv
module pcipar_gen #(
  parameter int AD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [AD_W/8-1:0] cbe_n_i,
  input  logic              drive_i,
  output logic              sum_o,
  output logic              par_o,
  output logic              par_oe_o
);
  localparam int BE_W = AD_W / 8;

  logic [BE_W-1:0] lane_par;
  logic            par_d, oe_d;

  // one partial parity per byte lane, including that lane's enable
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = ^{ad_i[g*8 +: 8], cbe_n_i[g]};
  end

  always_comb begin
    sum_o = ^lane_par;
    par_d = sum_o;
    oe_d  = drive_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= par_d;
      par_oe_o <= oe_d;
    end
  end
endmodule

// File: rtl/pcipar_chk.sv
module pcipar_chk
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  logic   drive_i,
  input  logic   sum_i,
  input  logic   par_i,
  input  logic   perr_en_i,
  input  logic   serr_en_i,
  input  logic   sts_clr_i,
  output logic   perr_n_o,
  output logic   serr_n_o,
  output logic   sts_perr_o
);
  // stage 1: phase under check and its local parity
  phase_e s1_kind_q, s1_kind_d;
  logic   s1_sum_q, s1_sum_d;
  // stage 2: error flags once the remote parity has arrived
  logic   e_addr_q, e_addr_d, e_data_q, e_data_d;
  // stage 3: outputs
  logic   perr_n_d, serr_n_d, sts_d, mism;

  always_comb begin
    s1_kind_d = drive_i ? PH_NONE : phase_i;
    s1_sum_d  = sum_i;
    mism      = s1_sum_q ^ par_i;
    e_addr_d  = mism && (s1_kind_q == PH_ADDR);
    e_data_d  = mism && (s1_kind_q == PH_DATA);
    perr_n_d  = !(e_data_q && perr_en_i);
    serr_n_d  = !(e_addr_q && serr_en_i);
    if (e_addr_q || e_data_q) sts_d = 1'b1;
    else if (sts_clr_i)       sts_d = 1'b0;
    else                      sts_d = sts_perr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind_q  <= PH_NONE;
      s1_sum_q   <= 1'b0;
      e_addr_q   <= 1'b0;
      e_data_q   <= 1'b0;
      perr_n_o   <= 1'b1;
      serr_n_o   <= 1'b1;
      sts_perr_o <= 1'b0;
    end else begin
      s1_kind_q  <= s1_kind_d;
      s1_sum_q   <= s1_sum_d;
      e_addr_q   <= e_addr_d;
      e_data_q   <= e_data_d;
      perr_n_o   <= perr_n_d;
      serr_n_o   <= serr_n_d;
      sts_perr_o <= sts_d;
    end
  end

  // R6
  perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(perr_en_i));
  // R5
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> $past(serr_en_i));
  // R4
  serr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |=> serr_n_o);
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n_o || !serr_n_o) |-> sts_perr_o);
  // R8
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_perr_o) |-> $past(sts_clr_i));
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [AD_W/8-1:0] cbe_n_i,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              drive_i,
  input  logic              par_i,
  input  logic              perr_en_i,
  input  logic              serr_en_i,
  input  logic              sts_clr_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_n_o,
  output logic              serr_n_o,
  output logic              sts_perr_o
);
  phase_e phase;
  logic   sum;

  pcipar_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n_i (frame_n_i),
    .irdy_n_i  (irdy_n_i),
    .trdy_n_i  (trdy_n_i),
    .phase_o   (phase)
  );

  pcipar_gen #(.AD_W(AD_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_i     (ad_i),
    .cbe_n_i  (cbe_n_i),
    .drive_i  (drive_i),
    .sum_o    (sum),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  pcipar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase),
    .drive_i    (drive_i),
    .sum_i      (sum),
    .par_i      (par_i),
    .perr_en_i  (perr_en_i),
    .serr_en_i  (serr_en_i),
    .sts_clr_i  (sts_clr_i),
    .perr_n_o   (perr_n_o),
    .serr_n_o   (serr_n_o),
    .sts_perr_o (sts_perr_o)
  );

  // R7
  drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n_o || !serr_n_o) |-> !$past(drive_i, 3));
  // R3
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> !$past(frame_n_i, 3));
  // R6
  data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> ($past(irdy_n_i, 3) == 1'b0 && $past(trdy_n_i, 3) == 1'b0));
endmodule

// File: tb/sim_pci_parity_unit.sv
module sim_pci_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic        drive = 1'b0, par_in = 1'b0;
  logic        perr_en = 1'b1, serr_en = 1'b1, sts_clr = 1'b0;
  logic        par_o, par_oe_o, perr_n_o, serr_n_o, sts_perr_o;

  int checks = 0, fails = 0, cycles = 0;
  logic last_sum = 1'b0;

  always #2 clk = ~clk;

  pci_parity_unit u0 (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .drive_i(drive), .par_i(par_in), .perr_en_i(perr_en),
    .serr_en_i(serr_en), .sts_clr_i(sts_clr), .par_o(par_o),
    .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
    .sts_perr_o(sts_perr_o)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { int kind; logic sum; } rec_t;  // kind: 0 none, 1 addr, 2 data
  rec_t rq[$];
  logic pq[$];
  logic m_idle;
  logic exp_par, exp_oe, exp_perr_n, exp_serr_n, exp_sts;

  always @(posedge clk) begin
    rec_t r;
    logic s, err, any;
    int k;
    if (!rst_n) begin
      rq.delete(); pq.delete();
      m_idle = 1; exp_par = 0; exp_oe = 0;
      exp_perr_n = 1; exp_serr_n = 1; exp_sts = 0;
    end else begin
      s = ^{ad, cbe_n};
      k = 0;
      if (m_idle && !frame_n) k = 1;            // R3 address phase
      else if (!irdy_n && !trdy_n) k = 2;       // R3 data phase
      if (drive) k = 0;                         // R7 nothing checked while driving
      m_idle = frame_n && irdy_n;
      r.kind = k; r.sum = s;
      rq.push_back(r); pq.push_back(par_in);
      exp_par = s; exp_oe = drive;
      exp_perr_n = 1; exp_serr_n = 1; any = 0;
      if (rq.size() == 3) begin
        err = rq[0].sum != pq[1];
        if (err && rq[0].kind == 1) begin any = 1; if (serr_en) exp_serr_n = 0; end
        if (err && rq[0].kind == 2) begin any = 1; if (perr_en) exp_perr_n = 0; end
        void'(rq.pop_front()); void'(pq.pop_front());
      end
      if (any) exp_sts = 1;
      else if (sts_clr) exp_sts = 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 par_o", par_o, exp_par);
    chk("R2 par_oe_o", par_oe_o, exp_oe);
    chk("R4 R5 serr_n_o", serr_n_o, exp_serr_n);
    chk("R6 R7 perr_n_o", perr_n_o, exp_perr_n);
    chk("R8 sts_perr_o", sts_perr_o, exp_sts);
  endtask

  // one bus clock: drive lines, parity for previous clock (optionally flipped)
  task automatic cyc(input logic f, input logic i, input logic t,
                     input logic d, input logic flip);
    ad = $urandom; cbe_n = 4'($urandom);
    frame_n = f; irdy_n = i; trdy_n = t; drive = d;
    par_in = last_sum ^ flip;
    last_sum = ^{ad, cbe_n};
    @(negedge clk);
    cycles++;
    compare();
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 par_o", par_o, 1'b0);
    chk("R9 par_oe_o", par_oe_o, 1'b0);
    chk("R9 perr_n_o", perr_n_o, 1'b1);
    chk("R9 serr_n_o", serr_n_o, 1'b1);
    chk("R9 sts_perr_o", sts_perr_o, 1'b0);
    rst_n = 1'b1;
    cyc(1,1,1,0,0); cyc(1,1,1,0,0);

    // R1 R2 R7: local agent drives, bad remote parity must be ignored
    cyc(0,1,1,1,0); cyc(0,0,0,1,1); cyc(1,0,0,1,1); cyc(1,1,1,1,1);
    cyc(1,1,1,0,0); cyc(1,1,1,0,0); cyc(1,1,1,0,0);
    chk("R7 sticky untouched", sts_perr_o, 1'b0);

    // R3 R4: bad address parity with system-error enable set
    cyc(0,1,1,0,0); cyc(0,0,0,0,1); cyc(1,0,0,0,0); cyc(1,1,1,0,0);
    cyc(1,1,1,0,0);
    // R8 clear the flag
    sts_clr = 1; cyc(1,1,1,0,0); sts_clr = 0; cyc(1,1,1,0,0);

    // R5: same error with enable cleared, sticky still set (R8)
    serr_en = 0;
    cyc(0,1,1,0,0); cyc(0,0,0,0,1); cyc(1,0,0,0,0); cyc(1,1,1,0,0);
    cyc(1,1,1,0,0);
    serr_en = 1;

    // R6: back-to-back bad data phases, wait state, long burst (R3 no new address)
    cyc(0,1,1,0,0); cyc(0,0,0,0,0); cyc(0,0,0,0,1); cyc(0,0,0,0,1);
    cyc(0,1,0,0,1); cyc(0,0,0,0,0); cyc(1,0,0,0,0); cyc(1,1,1,0,1);
    cyc(1,1,1,0,0); cyc(1,1,1,0,0);
    // R8 set wins over clear
    sts_clr = 1;
    cyc(0,1,1,0,0); cyc(1,0,0,0,0); cyc(1,1,1,0,1); cyc(1,1,1,0,0);
    cyc(1,1,1,0,0);
    sts_clr = 0;
    // R6 enable off
    perr_en = 0;
    cyc(0,1,1,0,0); cyc(1,0,0,0,0); cyc(1,1,1,0,1); cyc(1,1,1,0,0);
    cyc(1,1,1,0,0);
    perr_en = 1;

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      if (n % 97 == 0) begin perr_en = 1'($urandom); serr_en = 1'($urandom); end
      sts_clr = ($urandom % 8) == 0;
      cyc(1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 4) == 0, ($urandom % 5) == 0);
    end
    sts_clr = 0;
    cyc(1,1,1,0,0); cyc(1,1,1,0,0); cyc(1,1,1,0,0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule